// File: doc/BRIEF.md
# Operand Address Generator

This unit turns an addressing-mode code plus the register values that an instruction needs into the address of its operand and the memory space that address belongs to. It serves an 8-bit microcontroller core with a 16-bit program space. The four spaces are the low internal RAM, the special function register space, the external data space and the program space. From the instruction's own address and its byte length it also forms the next sequential PC. For the two jump modes it forms the branch target and raises a jump flag.

The decoder presents one request per cycle with `in_valid` high. Every output is registered, and the result of a request shows up one clock later with `out_valid` high. While no request arrives the previous result is held. All 16-bit sums wrap modulo 65536 and no carry is reported. The two pointer registers arrive as ports from a small register-file stub. Bit 0 of the register field picks which pointer an indirect access uses. Mode codes 11 to 15 are undefined and raise an illegal-mode flag.

Mode codes: 0 register, 1 direct, 2 pointer to internal RAM, 3 pointer to external low page, 4 data-pointer indirect, 5 8-bit immediate, 6 16-bit immediate, 7 accumulator plus data pointer, 8 accumulator plus PC, 9 indirect jump, 10 relative branch. Space codes: 0 internal RAM, 1 SFR, 2 external data, 3 program.

Top module: `opaddr_gen`

## Requirements
- R1: While reset is low, and afterwards until the first request, every output is zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high; with `in_valid` low the data outputs keep their last value.
- R3: Register mode (0) gives address `bank*8 + reg_sel` in space 0.
- R4: Direct mode (1) gives address `op_byte`; space is 0 when `op_byte` is below 80H and 1 (SFR) when it is 80H or above.
- R5: Pointer-to-internal mode (2) takes R0 when `reg_sel[0]`=0 and R1 when it is 1, and gives the low 7 bits of that pointer as the address in space 0.
- R6: Pointer-to-external mode (3) selects the pointer as in R5 and gives the whole 8-bit pointer, zero-extended to 16 bits, in space 2.
- R7: Data-pointer indirect mode (4) gives `dptr` as the address in space 2.
- R8: Immediate modes (5 and 6) set `out_imm` and give address `instr_addr+1` in space 3; no other mode sets `out_imm`.
- R9: Indexed modes give `dptr + acc` (mode 7) or `next_pc + acc` (mode 8) in space 3, with `acc` unsigned and the sum wrapping modulo 65536.
- R10: Indirect-jump mode (9) gives `dptr + acc` as both address and branch PC in space 3, and sets `out_jump`.
- R11: Relative mode (10) gives `next_pc + sign_extend(op_byte)` as both address and branch PC in space 3, and sets `out_jump`.
- R12: `out_next_pc` is `instr_addr + instr_len` modulo 65536 in every mode; in non-jump modes `out_branch_pc` equals `out_next_pc`.
- R13: Mode codes 11 to 15 set `out_illegal`, give address 0 in space 0, and clear `out_imm` and `out_jump`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing-mode code |
| instr_addr | input | 16 | Address of the current instruction |
| instr_len | input | 2 | Instruction length in bytes |
| reg_sel | input | 3 | Register field of the instruction |
| bank | input | 2 | Active register bank |
| r0_val | input | 8 | Pointer register 0 |
| r1_val | input | 8 | Pointer register 1 |
| dptr | input | 16 | Data pointer |
| acc | input | 8 | Accumulator |
| op_byte | input | 8 | Direct address or branch offset byte |
| out_valid | output | 1 | Result present |
| out_addr | output | 16 | Operand address |
| out_space | output | 2 | Address space code |
| out_imm | output | 1 | Operand is immediate |
| out_jump | output | 1 | Branch target taken |
| out_illegal | output | 1 | Undefined mode code |
| out_next_pc | output | 16 | Sequential next PC |
| out_branch_pc | output | 16 | PC to load next |

## Verification
The only state in this block is the output register, so a fault in it shows up at the ports one cycle after the request. It appears as a stale or wrong address, a space code on the wrong side of the 80H boundary, or an `out_valid` that lingers while the bench is idle. The wrapping sums deserve the closest look. An adder that is too narrow, or that extends the offset without its sign, gives a wrong address only at the edges. The stimulus therefore includes indexed sums past FFFFH, backward branches from address zero and the extreme offsets 7FH and 80H. Pointer selection is checked with R0 and R1 holding different values, so that taking the wrong register changes the address in the same cycle.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int MODE_W = 4;
  localparam int LEN_W  = 2;
  localparam int REG_W  = 3;
  localparam int BANK_W = 2;

  typedef enum logic [MODE_W-1:0] {
    M_REG      = 4'd0,
    M_DIRECT   = 4'd1,
    M_IND_INT  = 4'd2,
    M_IND_XLO  = 4'd3,
    M_IND_DPTR = 4'd4,
    M_IMM8     = 4'd5,
    M_IMM16    = 4'd6,
    M_IDX_DPTR = 4'd7,
    M_IDX_PC   = 4'd8,
    M_JMP_IDX  = 4'd9,
    M_REL      = 4'd10
  } mode_e;

  typedef enum logic [1:0] {
    SP_IRAM  = 2'd0,
    SP_SFR   = 2'd1,
    SP_XDATA = 2'd2,
    SP_CODE  = 2'd3
  } space_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    space_e            space;
    logic              imm;
    logic              jump;
    logic              illegal;
    logic [ADDR_W-1:0] next_pc;
    logic [ADDR_W-1:0] branch_pc;
  } result_t;

  localparam int RES_W = $bits(result_t);

  // Sequential advance: instruction address plus its length, wrapping.
  function automatic logic [ADDR_W-1:0] pc_advance(input logic [ADDR_W-1:0] a,
                                                   input logic [LEN_W-1:0]  len);
    return a + ADDR_W'(len);
  endfunction

  // Unsigned index added to a 16-bit base, wrapping.
  function automatic logic [ADDR_W-1:0] idx_sum(input logic [ADDR_W-1:0] base,
                                                input logic [DATA_W-1:0] ix);
    return base + ADDR_W'(ix);
  endfunction

  // Two's-complement byte offset added to the next PC, wrapping.
  function automatic logic [ADDR_W-1:0] rel_target(input logic [ADDR_W-1:0] nxt,
                                                   input logic [DATA_W-1:0] off);
    return nxt + {{(ADDR_W-DATA_W){off[DATA_W-1]}}, off};
  endfunction

endpackage

// File: rtl/oag_ptr_sel.sv
module oag_ptr_sel
  import opaddr_pkg::*;
(
  input  logic              sel_r1,
  input  logic [DATA_W-1:0] r0_val,
  input  logic [DATA_W-1:0] r1_val,
  output logic [DATA_W-1:0] ptr
);
  always_comb ptr = sel_r1 ? r1_val : r0_val;
endmodule

// File: rtl/oag_calc.sv
module oag_calc
  import opaddr_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic [LEN_W-1:0]  instr_len,
  input  logic [REG_W-1:0]  reg_sel,
  input  logic [BANK_W-1:0] bank,
  input  logic [DATA_W-1:0] ptr,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] op_byte,
  output result_t           res
);
  localparam int PAD_B = ADDR_W - DATA_W;
  localparam int PAD_R = ADDR_W - BANK_W - REG_W;
  localparam int LOW_W = DATA_W - 1;

  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] tgt_idx;
  logic [ADDR_W-1:0] tgt_rel;
  logic              direct_hi;

  always_comb begin
    nxt       = pc_advance(instr_addr, instr_len);
    tgt_idx   = idx_sum(dptr, acc);
    tgt_rel   = rel_target(nxt, op_byte);
    direct_hi = op_byte[DATA_W-1];
  end

  always_comb begin
    res           = '0;
    res.next_pc   = nxt;
    res.branch_pc = nxt;
    case (mode_e'(mode))
      M_REG: begin
        res.addr  = {{PAD_R{1'b0}}, bank, reg_sel};
        res.space = SP_IRAM;
      end
      M_DIRECT: begin
        res.addr  = {{PAD_B{1'b0}}, op_byte};
        res.space = direct_hi ? SP_SFR : SP_IRAM;
      end
      M_IND_INT: begin
        res.addr  = {{(ADDR_W-LOW_W){1'b0}}, ptr[LOW_W-1:0]};
        res.space = SP_IRAM;
      end
      M_IND_XLO: begin
        res.addr  = {{PAD_B{1'b0}}, ptr};
        res.space = SP_XDATA;
      end
      M_IND_DPTR: begin
        res.addr  = dptr;
        res.space = SP_XDATA;
      end
      M_IMM8, M_IMM16: begin
        res.addr  = pc_advance(instr_addr, LEN_W'(1));
        res.space = SP_CODE;
        res.imm   = 1'b1;
      end
      M_IDX_DPTR: begin
        res.addr  = tgt_idx;
        res.space = SP_CODE;
      end
      M_IDX_PC: begin
        res.addr  = idx_sum(nxt, acc);
        res.space = SP_CODE;
      end
      M_JMP_IDX: begin
        res.addr      = tgt_idx;
        res.branch_pc = tgt_idx;
        res.space     = SP_CODE;
        res.jump      = 1'b1;
      end
      M_REL: begin
        res.addr      = tgt_rel;
        res.branch_pc = tgt_rel;
        res.space     = SP_CODE;
        res.jump      = 1'b1;
      end
      default: begin
        res.illegal = 1'b1;
      end
    endcase
  end

  always_comb begin
    if (res.imm) begin
      AST_IMM_NOT_JUMP: assert (!res.jump && !res.illegal); // R8
    end
  end
endmodule

// File: rtl/oag_reg.sv
module oag_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import opaddr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic [LEN_W-1:0]  instr_len,
  input  logic [REG_W-1:0]  reg_sel,
  input  logic [BANK_W-1:0] bank,
  input  logic [DATA_W-1:0] r0_val,
  input  logic [DATA_W-1:0] r1_val,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] op_byte,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_space,
  output logic              out_imm,
  output logic              out_jump,
  output logic              out_illegal,
  output logic [ADDR_W-1:0] out_next_pc,
  output logic [ADDR_W-1:0] out_branch_pc
);
  logic [DATA_W-1:0] ptr_sel;
  result_t           calc_res;
  result_t           held_res;
  logic [RES_W-1:0]  held_bits;

  oag_ptr_sel u_ptr (
    .sel_r1 (reg_sel[0]),
    .r0_val (r0_val),
    .r1_val (r1_val),
    .ptr    (ptr_sel)
  );

  oag_calc u_calc (
    .mode       (mode),
    .instr_addr (instr_addr),
    .instr_len  (instr_len),
    .reg_sel    (reg_sel),
    .bank       (bank),
    .ptr        (ptr_sel),
    .dptr       (dptr),
    .acc        (acc),
    .op_byte    (op_byte),
    .res        (calc_res)
  );

  oag_reg #(.W(RES_W)) u_res_q (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (in_valid),
    .d     (calc_res),
    .q     (held_bits)
  );

  oag_reg #(.W(1)) u_vld_q (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (1'b1),
    .d     (in_valid),
    .q     (out_valid)
  );

  always_comb begin
    held_res      = result_t'(held_bits);
    out_addr      = held_res.addr;
    out_space     = held_res.space;
    out_imm       = held_res.imm;
    out_jump      = held_res.jump;
    out_illegal   = held_res.illegal;
    out_next_pc   = held_res.next_pc;
    out_branch_pc = held_res.branch_pc;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_addr) && $stable(out_next_pc)); // R2
  AST_DIRECT_SFR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == M_DIRECT && op_byte[DATA_W-1] |=> out_space == SP_SFR); // R4
  AST_DIRECT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == M_DIRECT && !op_byte[DATA_W-1]
    |=> out_space == SP_IRAM && out_addr[ADDR_W-1:DATA_W-1] == '0); // R4
  AST_RI_LOW128: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == M_IND_INT |=> out_addr[ADDR_W-1:DATA_W-1] == '0); // R5
  AST_RI_XPAGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == M_IND_XLO
    |=> out_space == SP_XDATA && out_addr[ADDR_W-1:DATA_W] == '0); // R6
  AST_IMM_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_imm |-> out_space == SP_CODE); // R8
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    out_jump |-> out_branch_pc == out_addr && out_space == SP_CODE); // R10
  AST_NEXT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_next_pc == ADDR_W'($past(instr_addr) + ADDR_W'($past(instr_len)))); // R12
  AST_NOJUMP_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_jump |-> out_branch_pc == out_next_pc); // R12
  AST_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode > M_REL |=> out_illegal && !out_imm && !out_jump); // R13
endmodule

// File: tb/opaddr_gen_bench.sv
module opaddr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] instr_addr = '0;
  logic [1:0]  instr_len = '0;
  logic [2:0]  reg_sel = '0;
  logic [1:0]  bank = '0;
  logic [7:0]  r0_val = '0, r1_val = '0, acc = '0, op_byte = '0;
  logic [15:0] dptr = '0;
  logic        out_valid, out_imm, out_jump, out_illegal;
  logic [15:0] out_addr, out_next_pc, out_branch_pc;
  logic [1:0]  out_space;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  opaddr_gen u_opaddr_gen (.*);

  typedef struct packed {
    logic [3:0]  mode;  logic [15:0] ia;   logic [1:0] len;
    logic [2:0]  rs;    logic [1:0]  bk;   logic [7:0] r0;  logic [7:0] r1;
    logic [15:0] dp;    logic [7:0]  a;    logic [7:0] ob;
    logic [15:0] eaddr; logic [1:0]  esp;  logic [2:0] efl; logic [15:0] ebr;
  } vec_t;

  // efl = {imm, jump, illegal}
  localparam int NV = 23;
  localparam logic [111:0] TV [NV] = '{
    {4'h0,16'h0100,2'd1,3'd5,2'd2,8'h00,8'h00,16'h0000,8'h00,8'h00,16'h0015,2'd0,3'b000,16'h0101},
    {4'h1,16'h0102,2'd2,3'd0,2'd0,8'h00,8'h00,16'h0000,8'h00,8'h30,16'h0030,2'd0,3'b000,16'h0104},
    {4'h1,16'h0104,2'd2,3'd0,2'd0,8'h00,8'h00,16'h0000,8'h00,8'h7F,16'h007F,2'd0,3'b000,16'h0106},
    {4'h1,16'h0106,2'd2,3'd0,2'd0,8'h00,8'h00,16'h0000,8'h00,8'h80,16'h0080,2'd1,3'b000,16'h0108},
    {4'h1,16'h0108,2'd2,3'd0,2'd0,8'h00,8'h00,16'h0000,8'h00,8'hE0,16'h00E0,2'd1,3'b000,16'h010A},
    {4'h2,16'h0200,2'd1,3'd0,2'd0,8'h30,8'h55,16'h0000,8'h00,8'h00,16'h0030,2'd0,3'b000,16'h0201},
    {4'h2,16'h0201,2'd1,3'd3,2'd0,8'h30,8'hC5,16'h0000,8'h00,8'h00,16'h0045,2'd0,3'b000,16'h0202},
    {4'h3,16'h0202,2'd1,3'd1,2'd0,8'h30,8'hC5,16'h0000,8'h00,8'h00,16'h00C5,2'd2,3'b000,16'h0203},
    {4'h3,16'h0203,2'd1,3'd0,2'd0,8'hFE,8'hC5,16'h0000,8'h00,8'h00,16'h00FE,2'd2,3'b000,16'h0204},
    {4'h4,16'h0204,2'd1,3'd0,2'd0,8'h00,8'h00,16'hABCD,8'h00,8'h00,16'hABCD,2'd2,3'b000,16'h0205},
    {4'h5,16'h0300,2'd2,3'd0,2'd0,8'h00,8'h00,16'h0000,8'h00,8'h00,16'h0301,2'd3,3'b100,16'h0302},
    {4'h6,16'hFFFF,2'd3,3'd0,2'd0,8'h00,8'h00,16'h0000,8'h00,8'h00,16'h0000,2'd3,3'b100,16'h0002},
    {4'h7,16'h0400,2'd1,3'd0,2'd0,8'h00,8'h00,16'h22F1,8'h30,8'h00,16'h2321,2'd3,3'b000,16'h0401},
    {4'h7,16'h0401,2'd1,3'd0,2'd0,8'h00,8'h00,16'hFFF0,8'hFF,8'h00,16'h00EF,2'd3,3'b000,16'h0402},
    {4'h8,16'h1000,2'd1,3'd0,2'd0,8'h00,8'h00,16'h0000,8'h20,8'h00,16'h1021,2'd3,3'b000,16'h1001},
    {4'h8,16'hFFFE,2'd1,3'd0,2'd0,8'h00,8'h00,16'h0000,8'h05,8'h00,16'h0004,2'd3,3'b000,16'hFFFF},
    {4'h9,16'h0300,2'd1,3'd0,2'd0,8'h00,8'h00,16'h4000,8'h10,8'h00,16'h4010,2'd3,3'b010,16'h4010},
    {4'hA,16'h2000,2'd2,3'd0,2'd0,8'h00,8'h00,16'h0000,8'h00,8'h35,16'h2037,2'd3,3'b010,16'h2037},
    {4'hA,16'h2000,2'd2,3'd0,2'd0,8'h00,8'h00,16'h0000,8'h00,8'h80,16'h1F82,2'd3,3'b010,16'h1F82},
    {4'hA,16'h0000,2'd2,3'd0,2'd0,8'h00,8'h00,16'h0000,8'h00,8'hFE,16'h0000,2'd3,3'b010,16'h0000},
    {4'hA,16'h0010,2'd3,3'd0,2'd0,8'h00,8'h00,16'h0000,8'h00,8'h7F,16'h0092,2'd3,3'b010,16'h0092},
    {4'hB,16'h0500,2'd1,3'd0,2'd0,8'h00,8'h00,16'h0000,8'h00,8'h00,16'h0000,2'd0,3'b001,16'h0501},
    {4'hF,16'h0501,2'd2,3'd0,2'd0,8'h00,8'h00,16'h0000,8'h00,8'h00,16'h0000,2'd0,3'b001,16'h0503}
  };

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5, 4'd6: return "R8";
      4'd7, 4'd8: return "R9";
      4'd9: return "R10";
      4'd10: return "R11";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    mode = v.mode; instr_addr = v.ia; instr_len = v.len; reg_sel = v.rs;
    bank = v.bk; r0_val = v.r0; r1_val = v.r1; dptr = v.dp; acc = v.a;
    op_byte = v.ob; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] exp_next;
    logic [54:0] act_all, exp_all;
    logic [15:0] held_addr;
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    check({out_valid, out_addr, out_space, out_imm, out_jump, out_illegal,
           out_next_pc, out_branch_pc} == '0, "R1", "reset outputs",
          {out_addr, out_next_pc, out_branch_pc}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!out_valid && out_addr == '0, "R1", "idle after reset",
          {out_valid, out_addr}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(TV[i]);
      apply(v);
      exp_next = v.ia + 16'(v.len);
      act_all = {out_valid, out_addr, out_space, out_imm, out_jump, out_illegal,
                 out_next_pc, out_branch_pc};
      exp_all = {1'b1, v.eaddr, v.esp, v.efl, exp_next, v.ebr};
      check(act_all == exp_all, req_of(v.mode), $sformatf("vector %0d", i),
            64'(act_all), 64'(exp_all));
      // R12: next PC in every mode
      check(out_next_pc == exp_next, "R12", $sformatf("next pc vector %0d", i),
            64'(out_next_pc), 64'(exp_next));
    end

    // R2: hold while idle, out_valid drops
    apply(vec_t'(TV[12]));
    held_addr = out_addr;
    @(negedge clk);
    mode = 4'd4; dptr = 16'h5555;
    repeat (3) @(negedge clk);
    check(!out_valid && out_addr == held_addr, "R2", "hold while idle",
          {out_valid, out_addr}, {1'b0, held_addr});

    // R2: back-to-back requests each produce a valid result
    @(negedge clk);
    mode = 4'd1; op_byte = 8'h22; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid && out_addr == 16'h0022, "R2", "back-to-back first",
          {out_valid, out_addr}, {1'b1, 16'h0022});
    mode = 4'd1; op_byte = 8'hA0;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_addr == 16'h00A0 && out_space == 2'd1, "R4",
          "back-to-back second", {out_valid, out_addr, out_space},
          {1'b1, 16'h00A0, 2'd1});

    // R1: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_addr == '0 && out_space == '0 && !out_valid && out_next_pc == '0,
          "R1", "reset after activity", {out_addr, out_next_pc}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule